// File: doc/BRIEF.md
# Bitwise Self-Routing Node Controller

This block is the electronic decision logic of one bufferless two-input, two-output switching node in a multistage deflection-routed fabric. A packet arrives on the north or the west input and leaves on the south output, which goes to the next cylinder inward, or on the east output, which stays on the same cylinder. The controller drives the two output gate enables. There is no storage for the packet. Each slot the controller must pick exactly one exit, or neither exit when no packet is present.

The node sits on one cylinder at a fixed height and angle, and all three are parameters. On an outer cylinder the node tests one address bit. The cylinder index selects that bit, and the node compares it with the matching bit of its own height. On the innermost cylinder the node compares the low address bits, which carry the destination angle, with its own angle. A packet whose angle does not match keeps circulating. An inner node can force a packet east by raising a blocking input. Whenever this node sends a packet east, it raises its own blocking output so that the node feeding its east neighbour holds back.

Time is split into slots of 257 clock ticks (0.1 ns each). The inputs are sampled once per slot. The gate enable then opens at a fixed tick and stays open across the whole packet window.

Top module: `node_route_ctrl`

## Requirements
- R1: While reset is held, and after its release until the first routing decision takes effect, gate_s, gate_e, defl_out and proto_err are all 0.
- R2: If neither n_frame nor w_frame is 1 at the sample tick, both gates and defl_out stay 0 for that slot, whatever the header and defl_in values are.
- R3: On an outer cylinder CYL (CYL < HT_BITS), the node tests address bit HDR_W-1-CYL and compares it with height bit HT_BITS-1-CYL. The address is HDR_W = HT_BITS+ANG_BITS bits wide: the height field is in the upper bits and the angle field in the lower ANG_BITS bits.
- R4: A framed packet whose tested bits match, with defl_in 0 at the sample tick, enables only gate_s.
- R5: A framed packet whose tested bits do not match, or any framed packet with defl_in 1 at the sample tick, enables only gate_e.
- R6: defl_out is 1 for exactly the slots in which the node routes a packet east. It is 0 for south and idle slots.
- R7: On the innermost cylinder (CYL == HT_BITS), the low ANG_BITS header bits are compared as one field with ANGLE. When they are equal and defl_in is 0, the packet goes south. Otherwise it goes east.
- R8: The inputs are sampled only at tick SAMPLE_AT (default 2) of the slot counter, which starts at 0 one cycle after the two-stage reset release and wraps after SLOT_TICKS-1 (default 257 ticks). The chosen gate is 1 exactly on ticks GATE_ON to GATE_OFF-1 (defaults 6 to 250). Changes to the inputs at any other tick have no effect on that slot.
- R9: gate_s and gate_e are never 1 in the same cycle.
- R10: If n_frame and w_frame are both 1 at the sample tick, proto_err is 1 for that slot and the north packet is routed. Otherwise proto_err is 0.
- R11: If only w_frame is 1, the decision uses w_hdr.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slot tick clock, 0.1 ns per tick |
| rst_n | input | 1 | Asynchronous active-low reset, released through two flops |
| n_frame | input | 1 | Frame detected on the north input |
| n_hdr | input | HDR_W | Header address bits seen on the north input |
| w_frame | input | 1 | Frame detected on the west input |
| w_hdr | input | HDR_W | Header address bits seen on the west input |
| defl_in | input | 1 | Blocking signal from the inner-cylinder node |
| gate_s | output | 1 | Enable for the south (inward) output gate |
| gate_e | output | 1 | Enable for the east (same-cylinder) output gate |
| defl_out | output | 1 | Blocking signal toward the node feeding the east neighbour |
| proto_err | output | 1 | Both inputs carried a frame in the same slot |

## Verification
The hardest case to reach is an input change that falls inside a slot but away from the sample tick. The gate must hold the decision taken at tick 2, even when the header and the blocking input change in the middle of the packet window. To reach this case, the stimulus aligns itself to the bench's own slot count. It drives one header at the start of the slot and drives a contrary header and blocking value 100 ticks later. A second instance on the innermost cylinder receives the same stimulus, so the single-bit compare and the angle-field compare are both exercised in the same slots, including slots with collisions and slots with an empty frame but a set header.

// File: rtl/node_route_pkg.sv
package node_route_pkg;
  typedef enum logic [1:0] {
    RT_IDLE  = 2'd0,
    RT_SOUTH = 2'd1,
    RT_EAST  = 2'd2
  } route_e;
endpackage

// File: rtl/node_slot_timer.sv
module node_slot_timer #(
  parameter int SLOT_TICKS = 257,
  parameter int SAMPLE_AT  = 2,
  parameter int GATE_ON    = 6,
  parameter int GATE_OFF   = 251
) (
  input  logic clk,
  input  logic rst_n,
  output logic sample_stb,
  output logic gate_win
);
  localparam int TW = $clog2(SLOT_TICKS);
  localparam logic [TW-1:0] T_LAST   = TW'(SLOT_TICKS - 1);
  localparam logic [TW-1:0] T_SAMPLE = TW'(SAMPLE_AT);
  localparam logic [TW-1:0] T_OPEN   = TW'(GATE_ON - 1);
  localparam logic [TW-1:0] T_CLOSE  = TW'(GATE_OFF - 1);

  logic [TW-1:0] tick_q, tick_d;
  logic          win_q, win_d;

  always_comb begin
    tick_d = (tick_q == T_LAST) ? '0 : tick_q + 1'b1;
    win_d  = win_q;
    if (tick_q == T_OPEN)       win_d = 1'b1;
    else if (tick_q == T_CLOSE) win_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tick_q <= '0;
      win_q  <= 1'b0;
    end else begin
      tick_q <= tick_d;
      win_q  <= win_d;
    end
  end

  assign sample_stb = (tick_q == T_SAMPLE);
  assign gate_win   = win_q;
endmodule

// File: rtl/node_route_decide.sv
module node_route_decide
  import node_route_pkg::*;
#(
  parameter int HT_BITS  = 2,
  parameter int ANG_BITS = 2,
  parameter int CYL      = 1,
  parameter int HEIGHT   = 2,
  parameter int ANGLE    = 1,
  localparam int HDR_W   = HT_BITS + ANG_BITS
) (
  input  logic             frame,
  input  logic [HDR_W-1:0] hdr,
  input  logic             defl_in,
  output route_e           route
);
  localparam logic [HT_BITS-1:0]  HT_VAL  = HT_BITS'(HEIGHT);
  localparam logic [ANG_BITS-1:0] ANG_VAL = ANG_BITS'(ANGLE);

  logic addr_ok;
  logic unused_hdr;
  assign unused_hdr = ^hdr;

  generate
    if (CYL < HT_BITS) begin : g_stage
      // outer cylinder: one address bit, taken from the top down
      assign addr_ok = (hdr[HDR_W-1-CYL] == HT_VAL[HT_BITS-1-CYL]);
    end else begin : g_inner
      // innermost cylinder: whole angle field against this node's angle
      assign addr_ok = (hdr[ANG_BITS-1:0] == ANG_VAL);
    end
  endgenerate

  always_comb begin
    if (!frame)                  route = RT_IDLE;
    else if (addr_ok && !defl_in) route = RT_SOUTH;
    else                          route = RT_EAST;
  end
endmodule

// File: rtl/node_route_ctrl.sv
module node_route_ctrl
  import node_route_pkg::*;
#(
  parameter int HT_BITS    = 2,
  parameter int ANG_BITS   = 2,
  parameter int CYL        = 1,
  parameter int HEIGHT     = 2,
  parameter int ANGLE      = 1,
  parameter int SLOT_TICKS = 257,
  parameter int SAMPLE_AT  = 2,
  parameter int GATE_ON    = 6,
  parameter int GATE_OFF   = 251,
  localparam int HDR_W     = HT_BITS + ANG_BITS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             n_frame,
  input  logic [HDR_W-1:0] n_hdr,
  input  logic             w_frame,
  input  logic [HDR_W-1:0] w_hdr,
  input  logic             defl_in,
  output logic             gate_s,
  output logic             gate_e,
  output logic             defl_out,
  output logic             proto_err
);
  logic [1:0] rst_sync_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[1];

  logic sample_stb, gate_win;

  node_slot_timer #(
    .SLOT_TICKS(SLOT_TICKS), .SAMPLE_AT(SAMPLE_AT),
    .GATE_ON(GATE_ON), .GATE_OFF(GATE_OFF)
  ) u_timer (
    .clk(clk), .rst_n(rst_sync_n),
    .sample_stb(sample_stb), .gate_win(gate_win)
  );

  // north wins the input mux; a collision is flagged, not resolved
  logic             sel_frame;
  logic [HDR_W-1:0] sel_hdr;
  assign sel_frame = n_frame | w_frame;
  assign sel_hdr   = n_frame ? n_hdr : w_hdr;

  route_e route_nx;

  node_route_decide #(
    .HT_BITS(HT_BITS), .ANG_BITS(ANG_BITS), .CYL(CYL),
    .HEIGHT(HEIGHT), .ANGLE(ANGLE)
  ) u_decide (
    .frame(sel_frame), .hdr(sel_hdr), .defl_in(defl_in), .route(route_nx)
  );

  route_e dec_q, dec_d;
  logic   err_q, err_d;

  always_comb begin
    dec_d = dec_q;
    err_d = err_q;
    if (sample_stb) begin
      dec_d = route_nx;
      err_d = n_frame & w_frame;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      dec_q <= RT_IDLE;
      err_q <= 1'b0;
    end else begin
      dec_q <= dec_d;
      err_q <= err_d;
    end
  end

  assign gate_s    = gate_win && (dec_q == RT_SOUTH);
  assign gate_e    = gate_win && (dec_q == RT_EAST);
  assign defl_out  = (dec_q == RT_EAST);
  assign proto_err = err_q;
endmodule

// File: rtl/node_route_chk.sv
module node_route_chk #(
  parameter int SLOT_TICKS = 257,
  parameter int SAMPLE_AT  = 2,
  parameter int GATE_ON    = 6,
  parameter int GATE_OFF   = 251
) (
  input logic clk,
  input logic rst_q_n,
  input logic gate_s,
  input logic gate_e,
  input logic defl_out,
  input logic proto_err
);
  int ck;

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n)                ck <= 0;
    else if (ck == SLOT_TICKS-1) ck <= 0;
    else                         ck <= ck + 1;
  end

  assert_gates_excl_R9: assert property (@(posedge clk) disable iff (!rst_q_n)
    !(gate_s && gate_e));

  assert_east_warns_R6: assert property (@(posedge clk) disable iff (!rst_q_n)
    gate_e |-> defl_out);

  assert_defl_held_R6: assert property (@(posedge clk) disable iff (!rst_q_n)
    (ck != SAMPLE_AT + 1) |-> $stable(defl_out));

  assert_gate_window_R8: assert property (@(posedge clk) disable iff (!rst_q_n)
    (gate_s || gate_e) |-> (ck >= GATE_ON && ck < GATE_OFF));

  assert_gate_held_R8: assert property (@(posedge clk) disable iff (!rst_q_n)
    (ck > GATE_ON && ck < GATE_OFF) |-> ($stable(gate_s) && $stable(gate_e)));

  assert_err_held_R10: assert property (@(posedge clk) disable iff (!rst_q_n)
    (ck != SAMPLE_AT + 1) |-> $stable(proto_err));
endmodule

bind node_route_ctrl node_route_chk #(
  .SLOT_TICKS(SLOT_TICKS), .SAMPLE_AT(SAMPLE_AT),
  .GATE_ON(GATE_ON), .GATE_OFF(GATE_OFF)
) u_chk (
  .clk(clk), .rst_q_n(rst_sync_n),
  .gate_s(gate_s), .gate_e(gate_e),
  .defl_out(defl_out), .proto_err(proto_err)
);

// File: tb/node_route_ctrl_bench.sv
module node_route_ctrl_bench;
  localparam int SLOT = 257;
  localparam int SMP  = 2;
  localparam int GON  = 6;
  localparam int GOFF = 251;
  localparam logic [1:0] HT_V  = 2'd2;
  localparam logic [1:0] ANG_V = 2'd1;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, n_frame, w_frame, defl_in;
  logic [3:0] n_hdr, w_hdr;
  logic [1:0] gs, ge, dout, perr;

  node_route_ctrl #(.CYL(1)) u_node_route_ctrl (
    .clk(clk), .rst_n(rst_n), .n_frame(n_frame), .n_hdr(n_hdr),
    .w_frame(w_frame), .w_hdr(w_hdr), .defl_in(defl_in),
    .gate_s(gs[0]), .gate_e(ge[0]), .defl_out(dout[0]), .proto_err(perr[0]));

  node_route_ctrl #(.CYL(2)) u_node_route_ctrl_inner (
    .clk(clk), .rst_n(rst_n), .n_frame(n_frame), .n_hdr(n_hdr),
    .w_frame(w_frame), .w_hdr(w_hdr), .defl_in(defl_in),
    .gate_s(gs[1]), .gate_e(ge[1]), .defl_out(dout[1]), .proto_err(perr[1]));

  int total = 0, bad = 0;
  string cur_req = "R1";
  bit done = 0, chk_on = 0;

  // behavioural reference: 0 idle, 1 south, 2 east
  bit s1 = 0, s2 = 0;
  int m_tick = 0;
  int m_dec[2];
  bit m_err = 0;

  function automatic int ref_route(int cyl);
    logic [3:0] h;
    bit ok;
    if (!(n_frame || w_frame)) return 0;
    h = n_frame ? n_hdr : w_hdr;
    if (cyl < 2) ok = (h[3-cyl] == HT_V[1-cyl]);
    else         ok = (h[1:0] == ANG_V);
    return (ok && !defl_in) ? 1 : 2;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      s1 = 0; s2 = 0; m_tick = 0; m_dec[0] = 0; m_dec[1] = 0; m_err = 0;
    end else if (!s2) begin
      s2 = s1; s1 = 1;
    end else begin
      if (m_tick == SMP) begin
        m_dec[0] = ref_route(1);
        m_dec[1] = ref_route(2);
        m_err = n_frame && w_frame;
      end
      m_tick = (m_tick == SLOT-1) ? 0 : m_tick + 1;
    end
    chk_on = 1;
  end

  always @(negedge clk) begin
    if (chk_on && !done) begin
      for (int i = 0; i < 2; i++) begin
        bit win, es, ee, ed;
        win = (m_tick >= GON) && (m_tick < GOFF);
        es = win && m_dec[i] == 1;
        ee = win && m_dec[i] == 2;
        ed = (m_dec[i] == 2);
        total++;
        if (gs[i] !== es || ge[i] !== ee || dout[i] !== ed || perr[i] !== m_err) begin
          bad++;
          $display("FAIL %s inst%0d tick=%0d act s/e/d/err=%b%b%b%b exp=%b%b%b%b",
                   cur_req, i, m_tick, gs[i], ge[i], dout[i], perr[i], es, ee, ed, m_err);
        end
        total++;
        if (gs[i] && ge[i]) begin   // R9
          bad++;
          $display("FAIL R9 inst%0d both gates act=11 exp=not 11", i);
        end
      end
    end
  end

  task automatic run_slot(string req, bit nf, logic [3:0] nh, bit wf, logic [3:0] wh, bit dfl);
    while (m_tick != 0) @(negedge clk);
    cur_req = req;
    n_frame = nf; n_hdr = nh; w_frame = wf; w_hdr = wh; defl_in = dfl;
    repeat (SLOT) @(negedge clk);
  endtask

  task automatic run_mid_change(string req);
    while (m_tick != 0) @(negedge clk);
    cur_req = req;
    n_frame = 1; n_hdr = 4'b0001; w_frame = 0; w_hdr = 4'b0000; defl_in = 0;
    repeat (100) @(negedge clk);
    n_hdr = 4'b0110; defl_in = 1; w_frame = 1;
    repeat (SLOT - 100) @(negedge clk);
  endtask

  initial begin
    rst_n = 0; n_frame = 0; w_frame = 0; defl_in = 0; n_hdr = 0; w_hdr = 0;
    repeat (5) @(negedge clk);
    rst_n = 1;
    repeat (10) @(negedge clk);
    run_slot("R2", 0, 4'b0000, 0, 4'b0000, 0);
    run_slot("R4_R3_R7", 1, 4'b0001, 0, 4'b0000, 0);
    run_slot("R5_R6_R3", 1, 4'b0101, 0, 4'b0000, 0);
    run_slot("R5_defl", 1, 4'b0001, 0, 4'b0000, 1);
    run_slot("R11", 0, 4'b0101, 1, 4'b0010, 0);
    run_slot("R10", 1, 4'b0100, 1, 4'b0001, 0);
    run_slot("R2_hdr_set", 0, 4'b1111, 0, 4'b1111, 1);
    run_slot("R7_mismatch", 0, 4'b0000, 1, 4'b1011, 0);
    run_slot("R7_match_w", 0, 4'b0000, 1, 4'b1101, 0);
    run_mid_change("R8");
    run_slot("R6_idle", 0, 4'b0000, 0, 4'b0000, 0);
    run_slot("R10_clear", 1, 4'b1001, 0, 4'b0000, 0);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      done = 1;
      bad++; total++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule